// File: doc/BRIEF.md
# Serial Divider Configuration Receiver

This block is a write-only two-wire serial slave that sits in a system clock domain and receives a fixed-length configuration frame for a clock synthesizer. It oversamples the clock and data lines, finds START and STOP conditions, and checks the 7-bit address against one of two values picked by a select pin. Once the address matches, it acknowledges by pulling the data line low through an open-drain enable.

A frame holds an address byte with the write direction, one byte that is discarded, and then three payload bytes. These bytes carry a 9-bit feedback divider value, a 2-bit output divider code, two spread-direction flags and a 6-bit spread amount. Payload bytes go into shadow storage first. The active outputs are loaded only when a STOP ends a frame whose four post-address bytes were all received. A one-cycle strobe marks each load, so downstream logic can see that a serial update took place.

Top module: `divcfg_serial_slave`

## Requirements
- R1: After reset the active feedback divider reads 256, the output divider code reads 0, both spread flags and the spread amount read 0, the pull-down enable is off and the update strobe is low.
- R2: An address byte is accepted when its upper seven bits equal 1,1,0,1,1,S,0 (MSB first, S being the select pin) and its last bit (direction) is 0. An accepted address is acknowledged on the ninth clock.
- R3: An address byte that does not match, or that has its direction bit set, is not acknowledged. The pull-down stays off for the rest of that frame and the outputs do not change.
- R4: The pull-down enable is asserted only while SCL is low after the eighth bit of a byte. It stays on through the whole ninth SCL high phase and is released only after the following SCL fall.
- R5: The first payload byte maps MSB first to output-divider bits 1..0 followed by feedback-divider bits 8..3. The top three bits of the second payload byte are feedback-divider bits 2..0, and its lower five bits have no effect.
- R6: The third payload byte maps MSB first to the up-spread flag, the down-spread flag and spread amount bits 5..0.
- R7: The byte that follows the address is acknowledged, and its value affects no output.
- R8: Any byte after the third payload byte is not acknowledged and is not stored. A STOP after it still loads the complete frame that came before.
- R9: The active outputs change only on a STOP that follows all four post-address bytes. A STOP after a shorter frame, or a repeated START in the middle of a frame, loads nothing.
- R10: Each load raises the update strobe for exactly one clock, in the cycle where the new values first appear on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel_i | input | 1 | Selects which of the two addresses is decoded |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| m_div_o | output | 9 | Active feedback divider value |
| n_div_o | output | 2 | Active output divider code |
| spread_up_o | output | 1 | Active up-spread flag |
| spread_dn_o | output | 1 | Active down-spread flag |
| spread_amt_o | output | 6 | Active spread amount |
| update_o | output | 1 | One-cycle strobe when the active values are loaded |

## Verification
The STOP that loads the shadow bytes into the active outputs also clears the frame-complete state in the same cycle. A bug in ordering would either lose the load or let it happen twice. The bench sends STOP directly after a full frame, after a frame that ends with an extra unacknowledged byte, and after a frame that a repeated START aborted. It judges each case by counting update pulses at the ports and comparing the settled output fields with values taken from the byte layout.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;

  localparam int CFG_BYTE_W     = 8;
  localparam int CFG_POST_BYTES = 4;
  localparam int CFG_PAY_BYTES  = CFG_POST_BYTES - 1;
  localparam int CFG_M_W        = 9;
  localparam int CFG_N_W        = 2;
  localparam int CFG_AMT_W      = 6;
  localparam logic [CFG_M_W-1:0] CFG_M_RESET = 9'd256;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RECV   = 3'd1,
    ST_ACK_LO = 3'd2,
    ST_ACK_HI = 3'd3,
    ST_SKIP   = 3'd4
  } link_state_e;

  typedef struct packed {
    logic [CFG_N_W-1:0]   n;
    logic [CFG_M_W-1:0]   m;
    logic                 up;
    logic                 dn;
    logic [CFG_AMT_W-1:0] amt;
  } divcfg_t;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] pipe_q;
    logic [SYNC_STAGES-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[SYNC_STAGES-2:0], raw[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= pipe_d;
    end

    assign synced[g] = pipe_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= synced;
  end

  assign scl_lvl   = synced[1];
  assign sda_lvl   = synced[0];
  assign scl_rise  = synced[1] & ~prev_q[1];
  assign scl_fall  = ~synced[1] & prev_q[1];
  assign start_det = synced[1] & prev_q[1] & prev_q[0] & ~synced[0];
  assign stop_det  = synced[1] & prev_q[1] & ~prev_q[0] & synced[0];

endmodule

// File: rtl/i2c_cfg_link.sv
module i2c_cfg_link
  import divcfg_pkg::*;
#(
  parameter int          BYTE_W     = CFG_BYTE_W,
  parameter int          POST_BYTES = CFG_POST_BYTES,
  parameter logic [6:0]  ADDR_BASE  = 7'b1101100,
  parameter int          SEL_BIT    = 1,
  localparam int         IDX_W      = $clog2(POST_BYTES - 1),
  localparam int         BIT_W      = $clog2(BYTE_W),
  localparam int         CNT_W      = $clog2(POST_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              frame_full,
  output link_state_e       state_o
);

  link_state_e       state_q, state_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] sreg_q, sreg_d;
  logic              have_q, have_d;
  logic              addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              full_q, full_d;
  logic [6:0]        my_addr;
  logic              byte_last;
  logic              addr_hit;

  always_comb begin
    my_addr          = ADDR_BASE;
    my_addr[SEL_BIT] = addr_sel;
  end

  assign byte_last = (bit_q == BIT_W'(BYTE_W - 1));
  assign addr_hit  = (sreg_q[BYTE_W-1:1] == my_addr) && !sreg_q[0];

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sreg_d  = sreg_q;
    have_d  = have_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    full_d  = full_q;
    wr_en   = 1'b0;
    wr_idx  = '0;
    if (start_det) begin
      state_d = ST_RECV;
      bit_d   = '0;
      have_d  = 1'b0;
      addr_d  = 1'b1;
      cnt_d   = '0;
      full_d  = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      have_d  = 1'b0;
      full_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_RECV: begin
          if (scl_rise && !have_q) begin
            sreg_d = {sreg_q[BYTE_W-2:0], sda_lvl};
            if (byte_last) have_d = 1'b1;
            else           bit_d  = bit_q + BIT_W'(1);
          end
          if (scl_fall && have_q) begin
            have_d = 1'b0;
            bit_d  = '0;
            if (addr_q) begin
              addr_d  = 1'b0;
              state_d = addr_hit ? ST_ACK_LO : ST_SKIP;
            end else if (cnt_q < CNT_W'(POST_BYTES)) begin
              state_d = ST_ACK_LO;
              cnt_d   = cnt_q + CNT_W'(1);
              if (cnt_q != '0) begin
                wr_en  = 1'b1;
                wr_idx = IDX_W'(cnt_q - CNT_W'(1));
              end
              if (cnt_q == CNT_W'(POST_BYTES - 1)) full_d = 1'b1;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ACK_LO: if (scl_rise) state_d = ST_ACK_HI;
        ST_ACK_HI: if (scl_fall) state_d = ST_RECV;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sreg_q  <= '0;
      have_q  <= 1'b0;
      addr_q  <= 1'b0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sreg_q  <= sreg_d;
      have_q  <= have_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
    end
  end

  assign sda_pull   = (state_q == ST_ACK_LO) || (state_q == ST_ACK_HI);
  assign wr_byte    = sreg_q;
  assign frame_full = full_q;
  assign state_o    = state_q;

endmodule

// File: rtl/divcfg_regs.sv
module divcfg_regs
  import divcfg_pkg::*;
#(
  parameter int  BYTE_W  = CFG_BYTE_W,
  localparam int IDX_W   = $clog2(CFG_PAY_BYTES),
  localparam int HI_W    = CFG_M_W - (BYTE_W - CFG_N_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              stop_det,
  input  logic              frame_full,
  output divcfg_t           cfg_o,
  output logic              update_o
);

  logic [BYTE_W-1:0] sh0_q, sh0_d;
  logic [HI_W-1:0]   sh1_q, sh1_d;
  logic [BYTE_W-1:0] sh2_q, sh2_d;
  divcfg_t           act_q, act_d;
  logic              upd_q, upd_d;
  logic              commit;

  assign commit = stop_det & frame_full;

  always_comb begin
    sh0_d = sh0_q;
    sh1_d = sh1_q;
    sh2_d = sh2_q;
    if (wr_en) begin
      unique case (wr_idx)
        IDX_W'(0): sh0_d = wr_byte;
        IDX_W'(1): sh1_d = wr_byte[BYTE_W-1 -: HI_W];
        default:   sh2_d = wr_byte;
      endcase
    end
  end

  always_comb begin
    act_d = act_q;
    upd_d = commit;
    if (commit) begin
      act_d.n   = sh0_q[BYTE_W-1 -: CFG_N_W];
      act_d.m   = {sh0_q[BYTE_W-CFG_N_W-1:0], sh1_q};
      act_d.up  = sh2_q[BYTE_W-1];
      act_d.dn  = sh2_q[BYTE_W-2];
      act_d.amt = sh2_q[CFG_AMT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh0_q     <= '0;
      sh1_q     <= '0;
      sh2_q     <= '0;
      act_q.n   <= '0;
      act_q.m   <= CFG_M_RESET;
      act_q.up  <= 1'b0;
      act_q.dn  <= 1'b0;
      act_q.amt <= '0;
      upd_q     <= 1'b0;
    end else begin
      sh0_q <= sh0_d;
      sh1_q <= sh1_d;
      sh2_q <= sh2_d;
      act_q <= act_d;
      upd_q <= upd_d;
    end
  end

  assign cfg_o    = act_q;
  assign update_o = upd_q;

endmodule

// File: rtl/divcfg_serial_slave.sv
module divcfg_serial_slave
  import divcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 addr_sel_i,
  output logic                 sda_pull_o,
  output logic [CFG_M_W-1:0]   m_div_o,
  output logic [CFG_N_W-1:0]   n_div_o,
  output logic                 spread_up_o,
  output logic                 spread_dn_o,
  output logic [CFG_AMT_W-1:0] spread_amt_o,
  output logic                 update_o
);

  localparam int IDX_W = $clog2(CFG_PAY_BYTES);

  logic [1:0]            rst_pipe_q;
  logic                  rst_sync_n;
  logic                  scl_lvl, sda_lvl, scl_rise, scl_fall;
  logic                  start_det, stop_det;
  logic                  wr_en, frame_full;
  logic [IDX_W-1:0]      wr_idx;
  logic [CFG_BYTE_W-1:0] wr_byte;
  link_state_e           link_state;
  divcfg_t               cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_cfg_link u_link (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr_sel   (addr_sel_i),
    .sda_lvl    (sda_lvl),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_pull   (sda_pull_o),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_byte    (wr_byte),
    .frame_full (frame_full),
    .state_o    (link_state)
  );

  divcfg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_byte    (wr_byte),
    .stop_det   (stop_det),
    .frame_full (frame_full),
    .cfg_o      (cfg),
    .update_o   (update_o)
  );

  assign m_div_o      = cfg.m;
  assign n_div_o      = cfg.n;
  assign spread_up_o  = cfg.up;
  assign spread_dn_o  = cfg.dn;
  assign spread_amt_o = cfg.amt;

endmodule

// File: rtl/divcfg_serial_slave_chk.sv
module divcfg_serial_slave_chk
  import divcfg_pkg::*;
(
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 scl_lvl,
  input logic                 stop_det,
  input link_state_e          link_state,
  input logic                 sda_pull_o,
  input logic                 update_o,
  input logic [CFG_M_W-1:0]   m_div_o,
  input logic [CFG_N_W-1:0]   n_div_o,
  input logic                 spread_up_o,
  input logic                 spread_dn_o,
  input logic [CFG_AMT_W-1:0] spread_amt_o
);

  logic [CFG_M_W+CFG_N_W+CFG_AMT_W+1:0] outs;
  assign outs = {m_div_o, n_div_o, spread_up_o, spread_dn_o, spread_amt_o};

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    update_o |=> !update_o);

  assert_load_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    update_o |-> $past(stop_det));

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !update_o |-> (outs == $past(outs)));

  assert_pull_release_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(sda_pull_o) |-> !scl_lvl);

  assert_pull_onset_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sda_pull_o) |-> !scl_lvl);

  assert_quiet_skip_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((link_state == ST_SKIP) || (link_state == ST_IDLE)) |-> !sda_pull_o);

endmodule

bind divcfg_serial_slave divcfg_serial_slave_chk u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .scl_lvl      (scl_lvl),
  .stop_det     (stop_det),
  .link_state   (link_state),
  .sda_pull_o   (sda_pull_o),
  .update_o     (update_o),
  .m_div_o      (m_div_o),
  .n_div_o      (n_div_o),
  .spread_up_o  (spread_up_o),
  .spread_dn_o  (spread_dn_o),
  .spread_amt_o (spread_amt_o)
);

// File: tb/divcfg_serial_slave_bench.sv
module divcfg_serial_slave_bench;

  localparam int Q = 10;
  localparam logic [7:0] DUMMY = 8'hA5;

  typedef struct packed {
    logic       asel;
    logic [7:0] addr;
    logic [2:0] nb;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] b2;
    logic       commit;
    logic [8:0] exp_m;
    logic [1:0] exp_n;
    logic [7:0] exp_sp;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{1'b0, 8'hD8, 3'd4, 8'h65, 8'h60, 8'h83, 1'b1, 9'h12B, 2'd1, 8'h83},
    '{1'b1, 8'hDC, 3'd4, 8'hC0, 8'hFF, 8'hC4, 1'b1, 9'h007, 2'd3, 8'hC4},
    '{1'b0, 8'hDC, 3'd4, 8'h11, 8'h22, 8'h33, 1'b0, 9'h007, 2'd3, 8'hC4},
    '{1'b1, 8'hDD, 3'd4, 8'h11, 8'h22, 8'h33, 1'b0, 9'h007, 2'd3, 8'hC4},
    '{1'b1, 8'hDC, 3'd3, 8'h11, 8'h22, 8'h33, 1'b0, 9'h007, 2'd3, 8'hC4},
    '{1'b0, 8'hD8, 3'd5, 8'h20, 8'h00, 8'h42, 1'b1, 9'h100, 2'd0, 8'h42}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m, asel;
  logic       sda_pull_o, update_o, spread_up_o, spread_dn_o;
  logic [8:0] m_div_o;
  logic [1:0] n_div_o;
  logic [5:0] spread_amt_o;
  wire        sda_line = sda_m & ~sda_pull_o;

  int errors = 0;
  int checks = 0;
  int upd_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  divcfg_serial_slave u_divcfg_serial_slave (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .addr_sel_i   (asel),
    .sda_pull_o   (sda_pull_o),
    .m_div_o      (m_div_o),
    .n_div_o      (n_div_o),
    .spread_up_o  (spread_up_o),
    .spread_dn_o  (spread_dn_o),
    .spread_amt_o (spread_amt_o),
    .update_o     (update_o)
  );

  always @(posedge clk) begin
    if (rst_n && update_o) upd_cnt <= upd_cnt + 1;
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; idle(Q);
    scl_m = 1'b1; idle(Q);
    sda_m = 1'b0; idle(Q);
    scl_m = 1'b0; idle(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; idle(Q);
    scl_m = 1'b1; idle(Q);
    sda_m = 1'b1; idle(4 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, output bit released);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; idle(Q);
      scl_m = 1'b1; idle(2 * Q);
      scl_m = 1'b0; idle(Q);
    end
    sda_m = 1'b1; idle(Q);
    scl_m = 1'b1; idle(Q);
    ack = sda_pull_o;
    idle(Q);
    ack = ack & sda_pull_o;
    scl_m = 1'b0; idle(Q);
    released = !sda_pull_o;
  endtask

  task automatic check_outs(input string req, input logic [8:0] m, input logic [1:0] n,
                            input logic [7:0] sp);
    check(m_div_o == m, req, m_div_o, m);
    check(n_div_o == n, req, n_div_o, n);
    check({spread_up_o, spread_dn_o, spread_amt_o} == sp, req,
          {spread_up_o, spread_dn_o, spread_amt_o}, sp);
  endtask

  initial begin
    bit ack, rel, addr_ok;
    int u0;
    logic [7:0] b;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; asel = 1'b0;
    idle(6);
    rst_n = 1'b1;
    idle(6);

    // R1: reset values
    check_outs("R1 reset", 9'd256, 2'd0, 8'h00);
    check(sda_pull_o == 1'b0, "R1 pull", sda_pull_o, 0);
    check(update_o == 1'b0, "R1 strobe", update_o, 0);

    // table walk: R2 R3 R5 R6 R7 R8 R9 R10
    foreach (TBL[r]) begin
      asel = TBL[r].asel;
      u0 = upd_cnt;
      addr_ok = (TBL[r].addr[7:1] == {5'b11011, TBL[r].asel, 1'b0}) && !TBL[r].addr[0];
      bus_start();
      send_byte(TBL[r].addr, ack, rel);
      check(ack == addr_ok, "R2/R3 address ack", ack, addr_ok);
      if (ack) check(rel, "R4 release after ninth clock", rel, 1);
      for (int k = 0; k < int'(TBL[r].nb); k++) begin
        b = (k == 0) ? DUMMY : (k == 1) ? TBL[r].b0 : (k == 2) ? TBL[r].b1 :
            (k == 3) ? TBL[r].b2 : 8'hFF;
        send_byte(b, ack, rel);
        check(ack == (addr_ok && k < 4), "R7/R8/R3 data ack", ack, addr_ok && k < 4);
        if (ack) check(rel, "R4 release", rel, 1);
      end
      bus_stop();
      check(upd_cnt - u0 == int'(TBL[r].commit), "R9/R10 update count", upd_cnt - u0,
            TBL[r].commit);
      check_outs("R5/R6/R9 outputs", TBL[r].exp_m, TBL[r].exp_n, TBL[r].exp_sp);
    end

    // R9: repeated START in the middle of a frame loads nothing from the aborted part
    asel = 1'b1;
    u0 = upd_cnt;
    bus_start();
    send_byte(8'hDC, ack, rel);
    send_byte(DUMMY, ack, rel);
    send_byte(8'hFF, ack, rel);
    send_byte(8'hFF, ack, rel);
    bus_start();
    send_byte(8'hDC, ack, rel);
    send_byte(DUMMY, ack, rel);
    send_byte(8'h5A, ack, rel);
    bus_stop();
    check(upd_cnt - u0 == 0, "R9 repeated start short frame", upd_cnt - u0, 0);
    check_outs("R9 unchanged after abort", 9'h100, 2'd0, 8'h42);

    // R10 + R8: full frame, then the same STOP also clears the frame state
    u0 = upd_cnt;
    bus_start();
    send_byte(8'hDC, ack, rel);
    send_byte(DUMMY, ack, rel);
    send_byte(8'h9E, ack, rel);
    send_byte(8'hBF, ack, rel);
    send_byte(8'h3F, ack, rel);
    check(ack == 1'b1, "R6 third payload acked", ack, 1);
    bus_stop();
    check(upd_cnt - u0 == 1, "R10 single strobe", upd_cnt - u0, 1);
    check_outs("R5/R6 mapping", 9'h0F5, 2'd2, 8'h3F);
    u0 = upd_cnt;
    bus_start();
    bus_stop();
    check(upd_cnt - u0 == 0, "R9 empty frame after load", upd_cnt - u0, 0);

    done = 1'b1;
    report();
  end

endmodule